// File: doc/BRIEF.md
# Grouped Pin Interrupt Controller

This block turns a wide vector of general-purpose input pins into eight interrupt sources and drives one combined interrupt line toward the processor. Each of the eight groups watches a single pin and chooses it through a 4-bit selector. The selector names one byte of one 32-pin port, and group g always takes bit g of that byte. The group detects a programmed edge or level on its pin. When the condition occurs, the group sets a sticky pending flag. A per-group enable mask gates the flag before it reaches the interrupt line.

Software programs the block over a simple 32-bit register bus with an address, a write strobe, write data and combinational read data. A driver first sets each group's trigger code and pin selector, then enables the group in the mask register. From an interrupt handler it reads the masked status word and clears the groups it has served by writing ones to the acknowledge register. The pins pass through one register stage inside the block, so an edge on a pin sets the pending flag two clock edges later.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset the trigger, selector and mask registers read as zero, the masked status reads zero and `irq_out` is low.
- R2: The trigger word (offset 120) holds a 3-bit code for group g at bits g*3+2:g*3. The selector word (offset 124) holds a 4-bit field for group g at bits g*4+3:g*4. The mask (offset 128) uses bits 7:0. All three read back as written. The acknowledge offset 132 and any unmapped offset read as zero.
- R3: Group g monitors pin (sel/4)*32 + (sel%4)*8 + g, where sel is its selector field. No other pin affects that group.
- R4: Code 5 sets the pending flag on a 0-to-1 transition of the monitored pin and ignores 1-to-0 transitions. A pin change driven before clock edge k becomes visible in the status after edge k+1.
- R5: Code 6 sets the pending flag on a 1-to-0 transition only.
- R6: Code 7 sets the pending flag on either transition.
- R7: Code 2 (level high) and code 1 (level low) set the pending flag on every cycle the level holds, so an acknowledge does not clear the flag while the level persists.
- R8: Codes 0, 3 and 4 never set a pending flag.
- R9: Writing the acknowledge register clears the pending flag of every group whose data bit is 1. Bits that are 0 leave their flags unchanged.
- R10: When a trigger event and an acknowledge of the same group fall on the same clock edge, the pending flag stays set.
- R11: The masked status (offset 140) reads pending AND mask in bits 7:0. `irq_out` is high exactly when that value is nonzero, and a masked flag stays latched until it is acknowledged.
- R12: Changing a group's selector never creates an edge event from the difference between the old and new pins. Edges on the newly selected pin are then detected normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pins_in | input | 128 | Synchronous pin inputs, four ports of 32 |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The tests drive each trigger code with both pin directions, one code per group. A rising-only, a falling-only and a both-edge group seeing the same kind of toggles show which directions each code accepts. A level group held active and then acknowledged separates level behaviour from edge behaviour. The tests toggle a pin that the selector does not pick, and a pin at a remote selector position, to tell the pin-index arithmetic apart from a simple bit-g pick. Two further cases show the event winning over the clear and the selector change staying silent: an acknowledge written on the edge where an event lands, and a selector switch onto a pin that is already high.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;

    localparam int NGRP        = 8;
    localparam int SEL_W       = 4;
    localparam int TRIG_W      = 3;
    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 32;
    localparam int PORT_W      = 32;
    localparam int BYTE_W      = 8;
    localparam int BYTES_PER_P = PORT_W / BYTE_W;
    localparam int NPORT       = (1 << SEL_W) / BYTES_PER_P;
    localparam int PIN_W       = NPORT * PORT_W;
    localparam int IDX_W       = $clog2(PIN_W);

    localparam logic [ADDR_W-1:0] OFS_TRIG = ADDR_W'(120);
    localparam logic [ADDR_W-1:0] OFS_SEL  = ADDR_W'(124);
    localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(128);
    localparam logic [ADDR_W-1:0] OFS_ACK  = ADDR_W'(132);
    localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(140);

    typedef enum logic [TRIG_W-1:0] {
        TRG_OFF    = 3'd0,
        TRG_LVL_LO = 3'd1,
        TRG_LVL_HI = 3'd2,
        TRG_RSV3   = 3'd3,
        TRG_RSV4   = 3'd4,
        TRG_RISE   = 3'd5,
        TRG_FALL   = 3'd6,
        TRG_BOTH   = 3'd7
    } trig_e;

    typedef struct packed {
        trig_e             trig;
        logic [SEL_W-1:0]  sel;
        logic              en;
    } grp_cfg_t;

    // Pin index watched by group g for selector value sel.
    function automatic logic [IDX_W-1:0] pin_index(input logic [SEL_W-1:0] sel,
                                                   input int unsigned g);
        int unsigned v;
        v = (int'(sel) / BYTES_PER_P) * PORT_W
          + (int'(sel) % BYTES_PER_P) * BYTE_W + g;
        return v[IDX_W-1:0];
    endfunction

    // Trigger decision for one cycle; edges are gated while the selector settles.
    function automatic logic trig_hit(input trig_e t, input logic cur,
                                      input logic prev, input logic sel_chg);
        logic rise, fall;
        rise = cur & ~prev & ~sel_chg;
        fall = ~cur & prev & ~sel_chg;
        case (t)
            TRG_LVL_LO: return ~cur;
            TRG_LVL_HI: return cur;
            TRG_RISE:   return rise;
            TRG_FALL:   return fall;
            TRG_BOTH:   return rise | fall;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic trig_is_quiet(input trig_e t);
        return (t == TRG_OFF) || (t == TRG_RSV3) || (t == TRG_RSV4);
    endfunction

endpackage

// File: rtl/grp_regs.sv
module grp_regs
    import grp_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  we,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [NGRP-1:0]       pend,
    output logic [DATA_W-1:0]     rdata,
    output grp_cfg_t [NGRP-1:0]   cfg,
    output logic [NGRP-1:0]       ack,
    output logic [NGRP-1:0]       mask
);

    localparam int TRIG_BITS = NGRP * TRIG_W;
    localparam int SEL_BITS  = NGRP * SEL_W;

    logic [TRIG_BITS-1:0] trig_q;
    logic [SEL_BITS-1:0]  sel_q;
    logic [NGRP-1:0]      mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= '0;
            sel_q  <= '0;
            mask_q <= '0;
        end else if (we) begin
            case (addr)
                OFS_TRIG: trig_q <= wdata[TRIG_BITS-1:0];
                OFS_SEL:  sel_q  <= wdata[SEL_BITS-1:0];
                OFS_MASK: mask_q <= wdata[NGRP-1:0];
                default: ;
            endcase
        end
    end

    assign ack  = (we && addr == OFS_ACK) ? wdata[NGRP-1:0] : '0;
    assign mask = mask_q;

    for (genvar g = 0; g < NGRP; g++) begin : g_cfg
        assign cfg[g].trig = trig_e'(trig_q[g*TRIG_W +: TRIG_W]);
        assign cfg[g].sel  = sel_q[g*SEL_W +: SEL_W];
        assign cfg[g].en   = mask_q[g];
    end

    always_comb begin
        case (addr)
            OFS_TRIG: rdata = DATA_W'(trig_q);
            OFS_SEL:  rdata = DATA_W'(sel_q);
            OFS_MASK: rdata = DATA_W'(mask_q);
            OFS_STAT: rdata = DATA_W'(pend & mask_q);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/grp_pin_pick.sv
module grp_pin_pick
    import grp_irq_pkg::*;
#(
    parameter int unsigned GRP = 0
) (
    input  logic [PIN_W-1:0]  pins,
    input  logic [SEL_W-1:0]  sel,
    output logic              cur
);

    logic [IDX_W-1:0] idx;

    assign idx = pin_index(sel, GRP);
    assign cur = pins[idx];

endmodule

// File: rtl/grp_trig_unit.sv
module grp_trig_unit
    import grp_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cur,
    input  trig_e             trig,
    input  logic [SEL_W-1:0]  sel,
    input  logic              ack,
    output logic              pend
);

    logic             prev_q;
    logic [SEL_W-1:0] sel_seen_q;
    logic             pend_q;
    logic             sel_chg;
    logic             hit;

    assign sel_chg = (sel != sel_seen_q);
    assign hit     = trig_hit(trig, cur, prev_q, sel_chg);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q     <= 1'b0;
            sel_seen_q <= '0;
            pend_q     <= 1'b0;
        end else begin
            prev_q     <= cur;
            sel_seen_q <= sel;
            pend_q     <= (pend_q & ~ack) | hit;
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
    import grp_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [PIN_W-1:0]     pins_in,
    output logic                 irq_out
);

    logic [PIN_W-1:0]      pins_q;
    grp_cfg_t [NGRP-1:0]   cfg_w;
    logic [NGRP-1:0]       ack_w;
    logic [NGRP-1:0]       mask_w;
    logic [NGRP-1:0]       pend_w;
    logic [NGRP-1:0]       cur_w;

    always_ff @(posedge clk) begin
        if (rst) pins_q <= '0;
        else     pins_q <= pins_in;
    end

    grp_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .addr  (bus_addr),
        .we    (bus_we),
        .wdata (bus_wdata),
        .pend  (pend_w),
        .rdata (bus_rdata),
        .cfg   (cfg_w),
        .ack   (ack_w),
        .mask  (mask_w)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        grp_pin_pick #(.GRP(g)) u_pick (
            .pins (pins_q),
            .sel  (cfg_w[g].sel),
            .cur  (cur_w[g])
        );

        grp_trig_unit u_trig (
            .clk  (clk),
            .rst  (rst),
            .cur  (cur_w[g]),
            .trig (cfg_w[g].trig),
            .sel  (cfg_w[g].sel),
            .ack  (ack_w[g]),
            .pend (pend_w[g])
        );
    end

    assign irq_out = |(pend_w & mask_w);

endmodule

// File: rtl/grp_irq_ctrl_chk.sv
module grp_irq_ctrl_chk
    import grp_irq_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic                irq_out,
    input logic [NGRP-1:0]     pend,
    input logic [NGRP-1:0]     ack,
    input grp_cfg_t [NGRP-1:0] cfg
);

    logic [NGRP-1:0] quiet;

    always_comb begin
        for (int g = 0; g < NGRP; g++) quiet[g] = trig_is_quiet(cfg[g].trig);
    end

    // R1: the interrupt line is low in the cycle after a reset edge
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !irq_out);

    // R2: acknowledge offset reads zero
    assert_ack_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_ACK) |-> (bus_rdata == '0));

    // R8: groups with a quiet code never raise a new pending flag
    assert_quiet_no_set_R8: assert property (@(posedge clk) disable iff (rst)
        ((pend & ~$past(pend) & $past(quiet)) == '0));

    // R9: a pending flag only drops after an acknowledge of that group
    assert_clear_needs_ack_R9: assert property (@(posedge clk) disable iff (rst)
        (($past(pend) & ~pend & ~$past(ack)) == '0));

    // R11: interrupt line agrees with the status readback
    assert_irq_matches_stat_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_STAT) |-> ((bus_rdata[NGRP-1:0] != '0) == irq_out));

endmodule

bind grp_irq_ctrl grp_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .pend      (pend_w),
    .ack       (ack_w),
    .cfg       (cfg_w)
);

// File: tb/grp_irq_ctrl_tb.sv
module grp_irq_ctrl_tb;
    import grp_irq_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic               bus_we = 1'b0;
    logic [DATA_W-1:0]  bus_wdata = '0;
    logic [DATA_W-1:0]  bus_rdata;
    logic [PIN_W-1:0]   pins_in = '0;
    logic               irq_out;

    always #2 clk = ~clk;

    grp_irq_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pins_in   (pins_in),
        .irq_out   (irq_out)
    );

    typedef struct {
        logic [DATA_W-1:0] val;
        logic              irq;
        string             tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // Monitor: compares one expected item per read cycle, 1 ns after the falling edge.
    always @(negedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            n_chk++;
            if (bus_rdata !== e.val || irq_out !== e.irq) begin
                n_fail++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         e.tag, bus_rdata, irq_out, e.val, e.irq);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            bus_we = 1'b0;
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] v,
                      input logic i, input string t);
        exp_t e;
        @(negedge clk);
        bus_we   = 1'b0;
        bus_addr = a;
        e.val = v;
        e.irq = i;
        e.tag = t;
        q.push_back(e);
    endtask

    task automatic setpin(input int p, input logic v);
        @(negedge clk);
        bus_we     = 1'b0;
        pins_in[p] = v;
    endtask

    function automatic int pin_of(input int sel, input int g);
        return (sel / 4) * 32 + (sel % 4) * 8 + g;
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        logic [DATA_W-1:0] tw;
        logic [DATA_W-1:0] tw2;
        logic [DATA_W-1:0] sw;
        int p51;

        pins_in[5] = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(OFS_TRIG, 32'h0, 1'b0, "R1 trig after reset");
        rd(OFS_SEL,  32'h0, 1'b0, "R1 sel after reset");
        rd(OFS_MASK, 32'h0, 1'b0, "R1 mask after reset");
        rd(OFS_STAT, 32'h0, 1'b0, "R1 status after reset");

        // R2: program one code per group and read back
        tw = (32'd5 << 0) | (32'd6 << 3) | (32'd7 << 6) | (32'd5 << 9)
           | (32'd2 << 12) | (32'd1 << 15) | (32'd0 << 18) | (32'd3 << 21);
        sw = 32'd6 << 12;
        wr(OFS_TRIG, tw);
        wr(OFS_SEL, sw);
        wr(OFS_MASK, 32'hFF);
        rd(OFS_TRIG, tw, 1'b0, "R2 trig readback");
        rd(OFS_SEL, sw, 1'b0, "R2 sel readback");
        rd(OFS_MASK, 32'hFF, 1'b0, "R2 mask readback");
        rd(OFS_ACK, 32'h0, 1'b0, "R2 ack reads zero");
        rd(8'h10, 32'h0, 1'b0, "R2 unmapped reads zero");
        rd(OFS_STAT, 32'h0, 1'b0, "R2 status idle");

        // R4: rising edge and two-edge latency
        setpin(0, 1'b1);
        rd(OFS_STAT, 32'h00, 1'b0, "R4 latency one edge");
        rd(OFS_STAT, 32'h01, 1'b1, "R4 rising sets pending");

        // R9: zero bits keep, one bits clear
        wr(OFS_ACK, 32'h00);
        rd(OFS_STAT, 32'h01, 1'b1, "R9 zero ack no effect");
        wr(OFS_ACK, 32'hFFFF_FF01);
        rd(OFS_STAT, 32'h00, 1'b0, "R9 ack clears");
        setpin(0, 1'b0);
        idle(3);
        rd(OFS_STAT, 32'h00, 1'b0, "R4 falling ignored by rise code");

        // R5: falling-only group 1
        setpin(1, 1'b1);
        idle(3);
        rd(OFS_STAT, 32'h00, 1'b0, "R5 rising ignored by fall code");
        setpin(1, 1'b0);
        idle(3);
        rd(OFS_STAT, 32'h02, 1'b1, "R5 falling sets pending");
        wr(OFS_ACK, 32'h02);

        // R6: both-edge group 2
        setpin(2, 1'b1);
        idle(3);
        rd(OFS_STAT, 32'h04, 1'b1, "R6 rising on both code");
        wr(OFS_ACK, 32'h04);
        rd(OFS_STAT, 32'h00, 1'b0, "R6 cleared");
        setpin(2, 1'b0);
        idle(3);
        rd(OFS_STAT, 32'h04, 1'b1, "R6 falling on both code");
        wr(OFS_ACK, 32'h04);

        // R3: group 3 with selector 6 watches a remote pin
        p51 = pin_of(6, 3);
        setpin(3, 1'b1);
        idle(3);
        rd(OFS_STAT, 32'h00, 1'b0, "R3 unselected pin ignored");
        setpin(p51, 1'b1);
        idle(3);
        rd(OFS_STAT, 32'h08, 1'b1, "R3 selected pin triggers");
        wr(OFS_ACK, 32'h08);

        // R7: level high on group 4, level low on group 5
        setpin(4, 1'b1);
        idle(3);
        rd(OFS_STAT, 32'h10, 1'b1, "R7 level high pending");
        wr(OFS_ACK, 32'h10);
        rd(OFS_STAT, 32'h10, 1'b1, "R7 level high re-asserts after ack");
        setpin(4, 1'b0);
        idle(2);
        wr(OFS_ACK, 32'h10);
        rd(OFS_STAT, 32'h00, 1'b0, "R7 level released then acked");
        setpin(5, 1'b0);
        idle(3);
        rd(OFS_STAT, 32'h20, 1'b1, "R7 level low pending");
        setpin(5, 1'b1);
        idle(2);
        wr(OFS_ACK, 32'h20);
        rd(OFS_STAT, 32'h00, 1'b0, "R7 level low released");

        // R8: codes 0, 3 and 4 stay quiet
        setpin(6, 1'b1);
        setpin(7, 1'b1);
        idle(2);
        setpin(6, 1'b0);
        setpin(7, 1'b0);
        idle(3);
        rd(OFS_STAT, 32'h00, 1'b0, "R8 codes 0 and 3 quiet");
        tw2 = (tw & ~(32'h7 << 21)) | (32'd4 << 21);
        wr(OFS_TRIG, tw2);
        setpin(7, 1'b1);
        idle(2);
        setpin(7, 1'b0);
        idle(3);
        rd(OFS_STAT, 32'h00, 1'b0, "R8 code 4 quiet");

        // R11: masked flag stays latched
        wr(OFS_MASK, 32'hFE);
        setpin(0, 1'b1);
        idle(3);
        rd(OFS_STAT, 32'h00, 1'b0, "R11 masked group hidden");
        wr(OFS_MASK, 32'hFF);
        rd(OFS_STAT, 32'h01, 1'b1, "R11 unmask reveals latched flag");
        wr(OFS_ACK, 32'h01);

        // R10: event and acknowledge on the same edge
        setpin(2, 1'b1);
        idle(3);
        setpin(2, 1'b0);
        wr(OFS_ACK, 32'h04);
        rd(OFS_STAT, 32'h04, 1'b1, "R10 event wins over ack");
        wr(OFS_ACK, 32'h04);
        rd(OFS_STAT, 32'h00, 1'b0, "R10 later ack clears");

        // R12: selector switch onto a high pin is silent
        setpin(0, 1'b0);
        setpin(pin_of(1, 0), 1'b1);
        idle(3);
        rd(OFS_STAT, 32'h00, 1'b0, "R12 before selector switch");
        wr(OFS_SEL, sw | 32'd1);
        idle(3);
        rd(OFS_STAT, 32'h00, 1'b0, "R12 no false edge on switch");
        rd(OFS_SEL, sw | 32'd1, 1'b0, "R12 selector readback");
        setpin(pin_of(1, 0), 1'b0);
        setpin(pin_of(1, 0), 1'b1);
        idle(3);
        rd(OFS_STAT, 32'h01, 1'b1, "R12 new pin edge detected");

        idle(3);
        done = 1'b1;
        finish_run();
    end

endmodule